// File: doc/BRIEF.md
# Dual Panel Line Splitter

The block lets one display controller drive two identical LCD panels. The controller is set up for one virtual frame that is as wide as a panel and twice as tall, and it runs at twice the panel pixel clock. The block captures every incoming active line into line storage. After a vertical sync the lines alternate between the panels: the first line goes to panel 0, the second to panel 1, the third to panel 0, and so on.

Each pair of captured lines is played back to both panels at the same time, at half the input rate. The block generates the panel timing itself: a divided pixel clock, a horizontal sync, a data enable and a vertical sync. Playback starts in the cycle after the odd (panel 1) line of a pair has been fully captured. The next pair is captured into the other half of a ping-pong store while the current pair plays.

The horizontal total, the sync width, the back porch and the active width are configuration inputs. The software that drives them keeps them constant while a line is playing. The block stops all panel output if the configuration is inconsistent. It also stops all panel output if a new pair completes while the previous pair is still playing.

Top module: `dual_panel_splitter`

## Requirements
- R1: After reset, every panel output is 0, err_cfg is 0 (given a consistent configuration) and err_overrun is 0.
- R2: Lines are counted as runs of in_de high. After each rising edge of in_vsync the count restarts at 0. Even-numbered lines are delivered on pnl0_rgb and odd-numbered lines on pnl1_rgb. An unpaired trailing even line is never played.
- R3: A falling edge of in_de that ends an odd line starts playback in the next clock cycle, for both panels. No line plays before its pair is complete.
- R4: Each output pixel lasts two clock cycles. pnl_pclk is 0 in the first cycle and 1 in the second.
- R5: Counting output pixels from 0 at the start of a line, pnl_hsync is high for pixels 0 to cfg_h_sync-1. pnl_de is high for pixels cfg_h_sync+cfg_h_back up to, but not including, cfg_h_sync+cfg_h_back+cfg_active_w.
- R6: An output line lasts cfg_h_total pixels (2*cfg_h_total cycles). After that every panel output stays 0 until the next pair completes.
- R7: While pnl_de is high, output pixel cfg_h_sync+cfg_h_back+c carries captured pixel c of that panel's line. While pnl_de is low, the rgb outputs are 0.
- R8: pnl_vsync is high for the whole of the first output line after each input vertical sync, on both panels at once.
- R9: If a pair completes while the previous output line still has more than its final cycle to run, err_overrun is set. It stays set until reset and forces every panel output to 0.
- R10: err_cfg is 1 while cfg_h_sync+cfg_h_back+cfg_active_w exceeds cfg_h_total, or cfg_active_w exceeds MAX_W, or cfg_h_total is 0. While err_cfg is 1, every panel output is 0.
- R11: Capturing the next pair does not disturb the pixels being played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock (twice the panel rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vsync | input | 1 | Input vertical sync, active high |
| in_de | input | 1 | Input data enable |
| in_rgb | input | PIX_W | Input pixel |
| cfg_h_total | input | CFG_W | Output line length in panel pixels |
| cfg_h_sync | input | CFG_W | Output horizontal sync width in pixels |
| cfg_h_back | input | CFG_W | Output back porch in pixels |
| cfg_active_w | input | CFG_W | Active pixels per line |
| pnl_pclk | output | 1 | Divided panel pixel clock |
| pnl_hsync | output | 1 | Panel horizontal sync (shared) |
| pnl_vsync | output | 1 | Panel vertical sync (shared) |
| pnl_de | output | 1 | Panel data enable (shared) |
| pnl0_rgb | output | PIX_W | Panel 0 pixel data |
| pnl1_rgb | output | PIX_W | Panel 1 pixel data |
| err_cfg | output | 1 | Inconsistent configuration |
| err_overrun | output | 1 | Sticky: a pair arrived before playback finished |

## Verification
The assertions assume that the configuration stays fixed while a line is playing. They also assume that in_vsync never rises in the same cycle that in_de falls, and that every input line carries exactly cfg_active_w pixels. The stimulus changes the configuration only after the output has gone idle. It keeps vertical sync pulses in blanking and always sends complete lines. The overrun and inconsistent-configuration cases are driven on purpose, each in its own phase, with a reset afterwards where needed.

// File: rtl/dps_pkg.sv
package dps_pkg;
   localparam int unsigned CFG_W = 12;
   typedef logic [CFG_W-1:0] cfg_t;
endpackage

// File: rtl/dps_linebuf.sv
module dps_linebuf #(
   parameter int unsigned PIX_W  = 24,
   parameter int unsigned MAX_W  = 256,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wbank,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [PIX_W-1:0]  wdata,
   input  logic              rbank,
   input  logic [ADDR_W-1:0] raddr,
   output logic [PIX_W-1:0]  rdata
);
   logic [PIX_W-1:0] mem [2][MAX_W];

   always_ff @(posedge clk) begin
      if (we) mem[wbank][waddr] <= wdata;
   end

   assign rdata = mem[rbank][raddr];
endmodule

// File: rtl/dps_capture.sv
module dps_capture #(
   parameter int unsigned MAX_W  = 256,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vsync,
   input  logic              in_de,
   input  logic              busy,
   output logic              we,
   output logic              wpar,
   output logic              wbank,
   output logic [ADDR_W-1:0] waddr,
   output logic              rbank,
   output logic              trig,
   output logic              first,
   output logic              err_overrun
);
   localparam int unsigned CNT_W = ADDR_W + 1;
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_W);

   logic             de_q, vs_q, fall, vs_rise;
   logic [CNT_W-1:0] col;

   assign fall    = de_q & ~in_de;
   assign vs_rise = in_vsync & ~vs_q;
   assign we      = in_de && (col < MAX_C);
   assign waddr   = col[ADDR_W-1:0];
   assign trig    = fall & wpar & ~vs_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         de_q <= 1'b0;
         vs_q <= 1'b0;
         col <= '0;
         wpar <= 1'b0;
         wbank <= 1'b0;
         rbank <= 1'b1;
         first <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         de_q <= in_de;
         vs_q <= in_vsync;
         if (fall) col <= '0;
         else if (we) col <= col + 1'b1;
         if (vs_rise) begin
            wpar <= 1'b0;
            first <= 1'b1;
         end else if (fall) begin
            wpar <= ~wpar;
            if (wpar) begin
               wbank <= ~wbank;
               rbank <= wbank;
               first <= 1'b0;
               if (busy) err_overrun <= 1'b1;
            end
         end
      end
   end

   // R2: a vertical sync restarts the line parity at panel 0
   a_r2_parity_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vsync && !vs_q) |=> !wpar);
   // R9: the overrun flag is sticky
   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun |=> err_overrun);
endmodule

// File: rtl/dps_timing.sv
module dps_timing #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic                first,
   input  dps_pkg::cfg_t       h_total,
   input  dps_pkg::cfg_t       h_sync,
   input  dps_pkg::cfg_t       h_back,
   input  dps_pkg::cfg_t       active_w,
   output logic                run,
   output logic                ph,
   output logic                busy,
   output logic                hs,
   output logic                de,
   output logic                vs,
   output logic [ADDR_W-1:0]   idx
);
   import dps_pkg::*;

   cfg_t             cnt;
   logic             vsl, last;
   logic [CFG_W:0]   start;
   logic [CFG_W+1:0] stop;

   assign last  = ph && (cnt == h_total - 1'b1);
   assign busy  = run && !last;
   assign start = {1'b0, h_sync} + {1'b0, h_back};
   assign stop  = {1'b0, start} + {2'b0, active_w};
   assign hs    = run && (cnt < h_sync);
   assign de    = run && ({1'b0, cnt} >= start) && ({2'b0, cnt} < stop);
   assign vs    = run && vsl;
   assign idx   = ADDR_W'({1'b0, cnt} - start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         ph <= 1'b0;
         cnt <= '0;
         vsl <= 1'b0;
      end else if (trig) begin
         run <= 1'b1;
         ph <= 1'b0;
         cnt <= '0;
         vsl <= first;
      end else if (run) begin
         ph <= ~ph;
         if (ph) begin
            if (last) run <= 1'b0;
            else cnt <= cnt + 1'b1;
         end
      end
   end

   // R5: the active window never overlaps the sync pulse
   a_r5_de_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !hs);
   // R6: a line ends only after its last pixel
   a_r6_line_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> ($past(cnt) == $past(h_total) - 1'b1));
endmodule

// File: rtl/dual_panel_splitter.sv
module dual_panel_splitter #(
   parameter int unsigned PIX_W = 24,
   parameter int unsigned MAX_W = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vsync,
   input  logic                 in_de,
   input  logic [PIX_W-1:0]     in_rgb,
   input  dps_pkg::cfg_t        cfg_h_total,
   input  dps_pkg::cfg_t        cfg_h_sync,
   input  dps_pkg::cfg_t        cfg_h_back,
   input  dps_pkg::cfg_t        cfg_active_w,
   output logic                 pnl_pclk,
   output logic                 pnl_hsync,
   output logic                 pnl_vsync,
   output logic                 pnl_de,
   output logic [PIX_W-1:0]     pnl0_rgb,
   output logic [PIX_W-1:0]     pnl1_rgb,
   output logic                 err_cfg,
   output logic                 err_overrun
);
   import dps_pkg::*;
   localparam int unsigned ADDR_W = $clog2(MAX_W);
   localparam int unsigned NPANEL = 2;

   generate
      if (MAX_W < 2 || (1 << ADDR_W) != MAX_W) begin : g_bad_width
         $error("MAX_W must be a power of two of at least 2");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("PIX_W must be positive");
      end
   endgenerate

   logic              we, wpar, wbank, rbank, trig, first;
   logic [ADDR_W-1:0] waddr, idx;
   logic              run, ph, busy, hs, de, vs, halt;
   logic [PIX_W-1:0]  rd [NPANEL];
   logic [CFG_W+1:0]  need;

   dps_capture #(.MAX_W(MAX_W), .ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .in_de(in_de),
      .busy(busy), .we(we), .wpar(wpar), .wbank(wbank), .waddr(waddr),
      .rbank(rbank), .trig(trig), .first(first), .err_overrun(err_overrun));

   dps_timing #(.ADDR_W(ADDR_W)) u_tim (
      .clk(clk), .rst_n(rst_n), .trig(trig), .first(first),
      .h_total(cfg_h_total), .h_sync(cfg_h_sync), .h_back(cfg_h_back),
      .active_w(cfg_active_w), .run(run), .ph(ph), .busy(busy),
      .hs(hs), .de(de), .vs(vs), .idx(idx));

   for (genvar p = 0; p < NPANEL; p++) begin : g_pan
      dps_linebuf #(.PIX_W(PIX_W), .MAX_W(MAX_W), .ADDR_W(ADDR_W)) u_lb (
         .clk(clk), .we(we && (wpar == p[0])), .wbank(wbank), .waddr(waddr),
         .wdata(in_rgb), .rbank(rbank), .raddr(idx), .rdata(rd[p]));
   end

   assign need = {2'b0, cfg_h_sync} + {2'b0, cfg_h_back} + {2'b0, cfg_active_w};
   assign err_cfg = (need > {2'b0, cfg_h_total}) ||
                    (cfg_active_w > cfg_t'(MAX_W)) || (cfg_h_total == '0);
   assign halt = err_cfg | err_overrun;

   assign pnl_pclk  = run && ph && !halt;
   assign pnl_hsync = hs && !halt;
   assign pnl_vsync = vs && !halt;
   assign pnl_de    = de && !halt;
   assign pnl0_rgb  = pnl_de ? rd[0] : '0;
   assign pnl1_rgb  = pnl_de ? rd[1] : '0;

   // R3: playback starts in the cycle after the pair completes
   a_r3_replay_starts: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (run && !ph));
   // R11: a pixel holds across both halves of its period
   a_r11_pixel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (pnl_de && !pnl_pclk && !trig) |=> ($stable(pnl0_rgb) && $stable(pnl1_rgb)));
endmodule

// File: tb/sim_dual_panel_splitter.sv
`timescale 1ns/100ps
module sim_dual_panel_splitter;
   localparam int PW = 24;
   localparam int MW = 256;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_vsync = 1'b0, in_de = 1'b0;
   logic [PW-1:0] in_rgb = '0;
   logic [11:0] ht = 12'd16, hsw = 12'd2, hbp = 12'd2, aw = 12'd8;
   logic pclk, hsy, vsy, de, ecfg, eovr;
   logic [PW-1:0] rgb0, rgb1;

   dual_panel_splitter #(.PIX_W(PW), .MAX_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .in_de(in_de), .in_rgb(in_rgb),
      .cfg_h_total(ht), .cfg_h_sync(hsw), .cfg_h_back(hbp), .cfg_active_w(aw),
      .pnl_pclk(pclk), .pnl_hsync(hsy), .pnl_vsync(vsy), .pnl_de(de),
      .pnl0_rgb(rgb0), .pnl1_rgb(rgb1), .err_cfg(ecfg), .err_overrun(eovr));

   always #2.5 clk = ~clk;

   int nchk = 0, nfail = 0, cyc = 0;
   bit cmp_en = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference
   logic [PW-1:0] cap0[$], cap1[$], cur0[$], cur1[$];
   int m_par, m_t;
   bit m_first, m_act, m_ovr, m_vsl, m_deq, m_vsq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_par = 0; m_t = 0; m_first = 0; m_act = 0; m_ovr = 0; m_vsl = 0;
         m_deq = 0; m_vsq = 0;
      end else begin
         bit vr, fl, tg;
         vr = in_vsync && !m_vsq;
         fl = !in_de && m_deq;
         tg = fl && (m_par == 1) && !vr;
         if (in_de) begin
            if (!m_deq) begin
               if (m_par == 0) cap0.delete(); else cap1.delete();
            end
            if (m_par == 0) cap0.push_back(in_rgb); else cap1.push_back(in_rgb);
         end
         if (tg) begin
            if (m_act && m_t < 2*int'(ht) - 1) m_ovr = 1;
            m_act = 1; m_t = 0; cur0 = cap0; cur1 = cap1;
            m_vsl = m_first; m_first = 0;
         end else if (m_act) begin
            m_t++;
            if (m_t >= 2*int'(ht)) m_act = 0;
         end
         if (vr) begin m_par = 0; m_first = 1; end
         else if (fl) m_par = 1 - m_par;
         m_deq = in_de; m_vsq = in_vsync;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         bit ce, on, e_de;
         int p, s;
         logic [PW-1:0] e0, e1;
         ce = (int'(hsw) + int'(hbp) + int'(aw) > int'(ht)) || (int'(aw) > MW) || (ht == 0);
         on = m_act && !ce && !m_ovr;
         p = m_t / 2;
         s = int'(hsw) + int'(hbp);
         e_de = on && p >= s && p < s + int'(aw);
         e0 = '0; e1 = '0;
         if (e_de) begin
            if (p - s < cur0.size()) e0 = cur0[p - s];
            if (p - s < cur1.size()) e1 = cur1[p - s];
         end
         chk("R10 err_cfg", 32'(ecfg), 32'(ce));
         chk("R9 err_overrun", 32'(eovr), 32'(m_ovr));
         chk("R4 pclk", 32'(pclk), 32'(on && (m_t % 2 == 1)));
         chk("R3 R5 hsync", 32'(hsy), 32'(on && p < int'(hsw)));
         chk("R5 R6 de", 32'(de), 32'(e_de));
         chk("R8 vsync", 32'(vsy), 32'(on && m_vsl));
         chk("R2 R7 R11 pnl0", 32'(rgb0), 32'(e0));
         chk("R2 R7 R11 pnl1", 32'(rgb1), 32'(e1));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         nfail++; nchk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic vsync_pulse();
      in_vsync = 1'b1; step(2); in_vsync = 1'b0; step(6);
   endtask

   task automatic send_line(int fr, int ln, int npix, int total);
      for (int c = 0; c < npix; c++) begin
         in_de = 1'b1; in_rgb = {8'(fr), 8'(ln), 8'(c)}; step(1);
      end
      in_de = 1'b0; in_rgb = '0;
      step(total - npix);
   endtask

   task automatic frame(int fr, int nlines, int npix, int total);
      vsync_pulse();
      for (int l = 0; l < nlines; l++) send_line(fr, l, npix, total);
   endtask

   task automatic do_reset();
      cmp_en = 0; rst_n = 1'b0; step(3);
      @(negedge clk);
      chk("R1 reset hsync", 32'(hsy), 0);
      chk("R1 reset de", 32'(de), 0);
      chk("R1 reset vsync", 32'(vsy), 0);
      chk("R1 reset pclk", 32'(pclk), 0);
      chk("R1 reset rgb", 32'(rgb0 | rgb1), 0);
      chk("R1 reset err", 32'({ecfg, eovr}), 0);
      @(posedge clk); #1; rst_n = 1'b1; cmp_en = 1;
   endtask

   initial begin
      do_reset();
      step(4);
      // nominal configuration, exact pacing, even then odd line count
      frame(1, 6, 8, 16);
      frame(2, 5, 8, 16);
      frame(3, 4, 8, 16);
      step(40);
      // second geometry
      ht = 12'd12; hsw = 12'd1; hbp = 12'd3; aw = 12'd5;
      step(2);
      frame(4, 4, 5, 12);
      frame(5, 4, 5, 12);
      step(40);
      // inconsistent configuration
      ht = 12'd16; hsw = 12'd2; hbp = 12'd4; aw = 12'd12;
      step(2);
      @(negedge clk); chk("R10 sum too large", 32'(ecfg), 1);
      step(1);
      frame(6, 4, 12, 16);
      step(40);
      ht = 12'd400; hsw = 12'd2; hbp = 12'd2; aw = 12'd300;
      step(2);
      @(negedge clk); chk("R10 width above max", 32'(ecfg), 1);
      step(1);
      ht = 12'd16; hsw = 12'd2; hbp = 12'd2; aw = 12'd8;
      step(2);
      @(negedge clk); chk("R10 cleared", 32'(ecfg), 0);
      step(1);
      frame(7, 4, 8, 16);
      step(40);
      // input lines too short: overrun
      frame(8, 6, 8, 10);
      step(40);
      @(negedge clk);
      chk("R9 overrun set", 32'(eovr), 1);
      chk("R9 outputs off", 32'({hsy, de, vsy, pclk}), 0);
      step(1);
      do_reset();
      step(4);
      frame(9, 4, 8, 16);
      step(40);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule